// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects five interrupt requests: two active-low external pins, two timer overflow flags supplied by a timer block, and one combined serial flag. Each request passes through a global enable and its own enable. A one-bit priority then places it in a high or a low level. Inside each level a fixed polling order picks one winner. The winner's vector address is offered to the CPU on a valid/ready channel. The block also contains the external-pin detectors. Each pin can be set to latch a falling edge or to follow a low level.

Software programs three byte registers over a simple write-strobe bus. Reads are combinational. The controller tracks which levels are in service. A high-level request may interrupt low-level service. Requests at the same or a lower level wait until the CPU pulses the return strobe. When an offer is accepted, the controller clears the edge flag of that source. For a timer source it instead sends a one-cycle clear pulse to the timer block, in the same cycle as the acceptance. The serial flag is left for software to clear.

The vector channel follows these back-pressure rules. An offer raises `irq_valid` and holds `irq_vector` unchanged until the CPU asserts `irq_ready`. A transfer happens in any cycle where both are high. After a transfer, `irq_valid` stays low for at least one cycle, and the next winner is then chosen from the updated service state. Clearing the global enable is the one event that withdraws an offer before it is accepted.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_valid` is 0, `tmr_clr` is 0, and registers 0, 1 and 2 all read 0x00 while both pins are idle high.
- R2: Register address 0 holds the global enable in bit 7 and the source enables in bits 4:0. Bits 6:5 always read 0. While the global enable is 0, `irq_valid` is 0. Clearing the global enable withdraws a pending offer in the cycle after the write.
- R3: Sources use these index numbers: external 0 is 0, timer 0 is 1, external 1 is 2, timer 1 is 3, serial is 4. A source can request only while its bit at that index is 1 in the enable register.
- R4: The offered vector is 0x0003 + 8 × index: external 0 gives 0x0003, timer 0 gives 0x000B, external 1 gives 0x0013, timer 1 gives 0x001B, serial gives 0x0023.
- R5: Among requests of one level that are pending together, the lowest index wins.
- R6: Register address 1, bits 4:0 (same index positions), gives each source its level: 1 means high. A pending high request beats any pending low request.
- R7: While low-level service is active, only high-level requests are offered. While high-level service is active, nothing is offered.
- R8: A pulse on `irq_return` ends the high level if it is active, and otherwise ends the low level.
- R9: Register address 2 holds the pin mode bits: bit 0 for external 0 and bit 1 for external 1, where 1 means falling edge. Bits 2 and 3 read the request flags of external 0 and external 1. In edge mode, a pin sampled at 1 and then at 0 on consecutive clocks sets the flag. Accepting that source's vector clears it.
- R10: In level mode the request flag follows the inverted, sampled pin. It is not latched and not cleared by acceptance.
- R11: `tmr_clr[0]` or `tmr_clr[1]` pulses high for exactly the transfer cycle in which timer 0 or timer 1 is accepted, and at no other time.
- R12: Accepting the serial vector leaves the serial request pending.
- R13: While `irq_valid` is high and `irq_ready` is low, `irq_vector` stays unchanged. After a transfer, `irq_valid` is low for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address (0 enable, 1 level, 2 pin mode/flags) |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Combinational register read data |
| ext_pin_n | input | 2 | Active-low external interrupt pins |
| tmr_flag | input | 2 | Timer overflow flags from the timer block |
| ser_flag | input | 1 | Combined serial receive/transmit flag |
| irq_valid | output | 1 | Vector offer valid |
| irq_ready | input | 1 | CPU accepts the offered vector |
| irq_vector | output | VW | Offered vector address |
| irq_return | input | 1 | Return strobe: ends the active service level |
| tmr_clr | output | 2 | One-cycle clear pulses for the timer flags |

## Verification
Register writes take effect at the next edge. A timer, serial or enabled level-mode request shows up in the offer one edge after it is raised. Exceptions: a pin change in level mode needs one more edge for the sampling stage. A falling edge in edge mode needs two edges before the flag is set and a third before it is offered. `tmr_clr` and the transfer are due in the same cycle. The dropped offer and any flag clear are due at the edge that follows. The bench runs a behavioural model, advanced at every rising edge with the same inputs the design sees. It compares valid, vector, clear pulses and read data at every falling edge. Inputs change 1 ns after the rising edge, so every comparison sees settled values for exactly that cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC = 5;
  localparam int NEXT = 2;
  localparam int IDX_W = $clog2(NSRC);

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;

  localparam int REG_ENABLE = 0;
  localparam int REG_LEVEL  = 1;
  localparam int REG_PINCFG = 2;
  localparam int GLB_BIT    = 7;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NEXT-1:0] ext_req,
  output logic            glb_en,
  output logic [NSRC-1:0] src_en,
  output logic [NSRC-1:0] src_hi,
  output logic [NEXT-1:0] ext_edge,
  output logic [DW-1:0]   rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en   <= 1'b0;
      src_en   <= '0;
      src_hi   <= '0;
      ext_edge <= '0;
    end else if (wr) begin
      case (int'(addr))
        REG_ENABLE: begin
          glb_en <= wdata[GLB_BIT];
          src_en <= wdata[NSRC-1:0];
        end
        REG_LEVEL:  src_hi   <= wdata[NSRC-1:0];
        REG_PINCFG: ext_edge <= wdata[NEXT-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (int'(addr))
      REG_ENABLE: begin
        rdata[GLB_BIT]    = glb_en;
        rdata[NSRC-1:0]   = src_en;
      end
      REG_LEVEL:  rdata[NSRC-1:0] = src_hi;
      REG_PINCFG: begin
        rdata[NEXT-1:0]        = ext_edge;
        rdata[2*NEXT-1:NEXT]   = ext_req;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_ext_detect.sv
module irqc_ext_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic samp_now, samp_old, edge_flag;
  logic fall_seen;

  assign fall_seen = samp_old & ~samp_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_now  <= 1'b1;
      samp_old  <= 1'b1;
      edge_flag <= 1'b0;
    end else begin
      samp_now <= pin_n;
      samp_old <= samp_now;
      if (!edge_mode)     edge_flag <= 1'b0;
      else if (fall_seen) edge_flag <= 1'b1;
      else if (clr)       edge_flag <= 1'b0;
    end
  end

  assign req = edge_mode ? edge_flag : ~samp_now;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int N  = 5,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  hi,
  input  logic          act_hi,
  input  logic          act_lo,
  output logic          win_vld,
  output logic [IW-1:0] win_idx,
  output logic          win_hi
);
  logic [N-1:0]  hi_set, lo_set;
  logic          hi_any, lo_any;
  logic [IW-1:0] hi_idx, lo_idx;

  assign hi_set = pend & hi;
  assign lo_set = pend & ~hi;

  always_comb begin
    hi_any = 1'b0;
    lo_any = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hi_set[i]) begin
        hi_any = 1'b1;
        hi_idx = IW'(i);
      end
      if (lo_set[i]) begin
        lo_any = 1'b1;
        lo_idx = IW'(i);
      end
    end
  end

  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_hi  = 1'b0;
    if (!act_hi) begin
      if (hi_any) begin
        win_vld = 1'b1;
        win_idx = hi_idx;
        win_hi  = 1'b1;
      end else if (lo_any && !act_lo) begin
        win_vld = 1'b1;
        win_idx = lo_idx;
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 2,
  parameter int VW       = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [1:0]    ext_pin_n,
  input  logic [1:0]    tmr_flag,
  input  logic          ser_flag,
  output logic          irq_valid,
  input  logic          irq_ready,
  output logic [VW-1:0] irq_vector,
  input  logic          irq_return,
  output logic [1:0]    tmr_clr
);
  logic            glb_en;
  logic [NSRC-1:0] src_en, src_hi, src_flag, pend;
  logic [NEXT-1:0] ext_edge, ext_req, ext_clr;
  logic            win_vld, win_hi;
  logic [IDX_W-1:0] win_idx;
  logic            off_vld, off_hi;
  logic [IDX_W-1:0] off_idx;
  logic            act_hi, act_lo, act_hi_nx, act_lo_nx;
  logic            xfer;

  localparam src_e EXT_IDX [NEXT] = '{SRC_EXT0, SRC_EXT1};

  irqc_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ext_req(ext_req), .glb_en(glb_en), .src_en(src_en), .src_hi(src_hi),
    .ext_edge(ext_edge), .rdata(bus_rdata)
  );

  for (genvar e = 0; e < NEXT; e++) begin : g_ext
    assign ext_clr[e] = xfer && (off_idx == EXT_IDX[e]);
    irqc_ext_detect u_det (
      .clk(clk), .rst_n(rst_n), .pin_n(ext_pin_n[e]), .edge_mode(ext_edge[e]),
      .clr(ext_clr[e]), .req(ext_req[e])
    );
  end

  always_comb begin
    src_flag           = '0;
    src_flag[SRC_EXT0] = ext_req[0];
    src_flag[SRC_TMR0] = tmr_flag[0];
    src_flag[SRC_EXT1] = ext_req[1];
    src_flag[SRC_TMR1] = tmr_flag[1];
    src_flag[SRC_SER]  = ser_flag;
  end

  assign pend = src_flag & src_en & {NSRC{glb_en}};

  irqc_arbiter #(.N(NSRC), .IW(IDX_W)) u_arb (
    .pend(pend), .hi(src_hi), .act_hi(act_hi), .act_lo(act_lo),
    .win_vld(win_vld), .win_idx(win_idx), .win_hi(win_hi)
  );

  assign irq_valid  = off_vld & glb_en;
  assign xfer       = irq_valid & irq_ready;
  assign irq_vector = VW'(VEC_BASE) + VW'(off_idx) * VW'(VEC_STEP);
  assign tmr_clr[0] = xfer && (off_idx == SRC_TMR0);
  assign tmr_clr[1] = xfer && (off_idx == SRC_TMR1);

  always_comb begin
    act_hi_nx = act_hi;
    act_lo_nx = act_lo;
    if (irq_return) begin
      if (act_hi) act_hi_nx = 1'b0;
      else        act_lo_nx = 1'b0;
    end
    if (xfer) begin
      if (off_hi) act_hi_nx = 1'b1;
      else        act_lo_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_vld <= 1'b0;
      off_idx <= '0;
      off_hi  <= 1'b0;
      act_hi  <= 1'b0;
      act_lo  <= 1'b0;
    end else begin
      act_hi <= act_hi_nx;
      act_lo <= act_lo_nx;
      if (!glb_en || xfer) begin
        off_vld <= 1'b0;
      end else if (!off_vld && win_vld) begin
        off_vld <= 1'b1;
        off_idx <= win_idx;
        off_hi  <= win_hi;
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int VW       = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_valid,
  input logic          irq_ready,
  input logic [VW-1:0] irq_vector,
  input logic          irq_return,
  input logic [1:0]    tmr_clr,
  input logic          glb_en,
  input logic          act_hi,
  input logic          act_lo,
  input logic          off_hi
);
  assert_offer_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> (!glb_en || (irq_valid && $stable(irq_vector))));

  assert_gap_after_xfer_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> !irq_valid);

  assert_clr_needs_xfer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|tmr_clr) |-> (irq_valid && irq_ready));

  assert_clr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_clr));

  assert_vector_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (int'(irq_vector) >= VEC_BASE && int'(irq_vector) <= VEC_BASE + 4 * VEC_STEP
                   && ((int'(irq_vector) - VEC_BASE) % VEC_STEP) == 0));

  assert_high_blocks_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_hi |-> !irq_valid);

  assert_low_only_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_lo && irq_valid) |-> off_hi);

  assert_return_pops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && act_hi) |=> !act_hi);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_vector(irq_vector), .irq_return(irq_return), .tmr_clr(tmr_clr),
  .glb_en(glb_en), .act_hi(act_hi), .act_lo(act_lo), .off_hi(off_hi)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [1:0] ext_pin_n = 2'b11;
  logic [1:0] tmr_flag = 2'b00;
  logic       ser_flag = 1'b0;
  logic       irq_valid, irq_ready = 1'b0;
  logic [15:0] irq_vector;
  logic       irq_return = 1'b0;
  logic [1:0] tmr_clr;

  int vectors = 0, miscompares = 0;
  bit checking = 1'b0, done = 1'b0;
  string cur_req = "R1";
  logic [1:0] clr_seen = 2'b00;

  always #2 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ext_pin_n(ext_pin_n), .tmr_flag(tmr_flag), .ser_flag(ser_flag),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector),
    .irq_return(irq_return), .tmr_clr(tmr_clr)
  );

  // Behavioural reference model
  bit       m_glb = 0;
  bit [4:0] m_en = 0, m_pri = 0;
  bit [1:0] m_ty = 0, m_s1 = 2'b11, m_s2 = 2'b11, m_fl = 0;
  bit       m_ov = 0, m_oh = 0, m_ahi = 0, m_alo = 0;
  int       m_oi = 0;

  function automatic bit ext_req_m(int e);
    return m_ty[e] ? m_fl[e] : !m_s1[e];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_glb = 0; m_en = 0; m_pri = 0; m_ty = 0; m_s1 = 2'b11; m_s2 = 2'b11; m_fl = 0;
      m_ov = 0; m_oh = 0; m_ahi = 0; m_alo = 0; m_oi = 0;
    end else begin
      bit src[5];
      bit hs, winh;
      int win;
      bit [1:0] nf;
      src[0] = ext_req_m(0); src[1] = tmr_flag[0]; src[2] = ext_req_m(1);
      src[3] = tmr_flag[1];  src[4] = ser_flag;
      hs = m_ov && m_glb && irq_ready;
      win = -1; winh = 0;
      if (!m_ahi) begin
        for (int i = 0; i < 5; i++)
          if (win < 0 && m_glb && src[i] && m_en[i] && m_pri[i]) begin win = i; winh = 1; end
        if (!m_alo)
          for (int i = 0; i < 5; i++)
            if (win < 0 && m_glb && src[i] && m_en[i] && !m_pri[i]) win = i;
      end
      for (int e = 0; e < 2; e++) begin
        if (!m_ty[e]) nf[e] = 0;
        else if (m_s2[e] && !m_s1[e]) nf[e] = 1;
        else if (hs && m_oi == 2 * e) nf[e] = 0;
        else nf[e] = m_fl[e];
      end
      if (!m_glb || hs) m_ov = 0;
      else if (!m_ov && win >= 0) begin m_ov = 1; m_oi = win; m_oh = winh; end
      if (irq_return) begin if (m_ahi) m_ahi = 0; else m_alo = 0; end
      if (hs) begin if (m_oh) m_ahi = 1; else m_alo = 1; end
      if (bus_wr) begin
        case (bus_addr)
          2'd0: begin m_glb = bus_wdata[7]; m_en = bus_wdata[4:0]; end
          2'd1: m_pri = bus_wdata[4:0];
          2'd2: m_ty = bus_wdata[1:0];
          default: ;
        endcase
      end
      m_fl = nf;
      m_s2 = m_s1;
      m_s1 = ext_pin_n;
    end
  end

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    clr_seen = tmr_clr;
    if (checking) begin
      bit ev;
      logic [7:0] erd;
      bit [1:0] etc;
      ev = m_ov && m_glb;
      etc[0] = ev && irq_ready && m_oi == 1;
      etc[1] = ev && irq_ready && m_oi == 3;
      case (bus_addr)
        2'd0: erd = {m_glb, 2'b00, m_en};
        2'd1: erd = {3'b000, m_pri};
        2'd2: erd = {4'b0000, ext_req_m(1), ext_req_m(0), m_ty};
        default: erd = 8'h00;
      endcase
      cmp("irq_valid", int'(irq_valid), int'(ev));
      if (ev) cmp("irq_vector", int'(irq_vector), 3 + 8 * m_oi);
      cmp("tmr_clr", int'(tmr_clr), int'(etc));
      cmp("bus_rdata", int'(bus_rdata), int'(erd));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
      tmr_flag = tmr_flag & ~clr_seen;
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic serve();
    int n = 0;
    while (!irq_valid && n < 100) begin tick(); n++; end
    irq_ready = 1'b1;
    tick();
    irq_ready = 1'b0;
  endtask

  task automatic ret();
    irq_return = 1'b1;
    tick();
    irq_return = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    checking = 1'b1;
    tick(2);
    rst_n = 1'b1;
    // R1: reset state on all three registers
    cur_req = "R1";
    bus_addr = 2'd0; tick(2);
    bus_addr = 2'd1; tick(2);
    bus_addr = 2'd2; tick(2);

    // R2: enable register layout, global gate and withdrawal
    cur_req = "R2";
    wr_reg(2'd0, 8'hFF); bus_addr = 2'd0; tick(2);
    wr_reg(2'd0, 8'h1F);
    tmr_flag[0] = 1'b1; tick(4);
    wr_reg(2'd0, 8'h9F); tick(3);
    wr_reg(2'd0, 8'h1F); tick(2);
    wr_reg(2'd0, 8'h9F); tick(2);
    cur_req = "R11";   // timer 0 clear pulse with the transfer
    serve(); tick(2);
    cur_req = "R8";
    ret(); tick(2);

    // R3: per-source enable, serial masked then unmasked
    cur_req = "R3";
    wr_reg(2'd0, 8'h8F);
    ser_flag = 1'b1; tick(4);
    wr_reg(2'd0, 8'h9F); tick(2);
    cur_req = "R12";   // serial stays pending after acceptance
    serve(); tick(3);
    ret(); tick(3);
    serve(); ser_flag = 1'b0; tick(2);
    ret(); tick(2);

    // R5 / R4: all five low-level, fixed order and vector values
    cur_req = "R5";
    wr_reg(2'd2, 8'h03);
    ext_pin_n = 2'b00; tick(1); ext_pin_n = 2'b11;
    tmr_flag = 2'b11; ser_flag = 1'b1;
    tick(3);
    cur_req = "R4";
    for (int k = 0; k < 4; k++) begin serve(); tick(1); ret(); end
    serve(); ser_flag = 1'b0; tick(1); ret(); tick(2);

    // R6: high level beats lower index at low level
    cur_req = "R6";
    wr_reg(2'd1, 8'h10);
    tmr_flag[0] = 1'b1; ser_flag = 1'b1; tick(3);
    serve(); ser_flag = 1'b0; tick(2); ret();
    serve(); tick(1); ret(); tick(2);

    // R7: preemption rules
    cur_req = "R7";
    wr_reg(2'd1, 8'h08);
    tmr_flag[0] = 1'b1; tick(2);
    serve();
    ext_pin_n[0] = 1'b0; tick(1); ext_pin_n[0] = 1'b1; tick(5);
    tmr_flag[1] = 1'b1; tick(2);
    serve(); tick(3);
    cur_req = "R8";
    ret(); tick(4);
    ret(); tick(2);
    serve(); tick(1); ret(); tick(2);

    // R9: edge flag visible on the bus, cleared by acceptance
    cur_req = "R9";
    wr_reg(2'd1, 8'h00);
    bus_addr = 2'd2;
    ext_pin_n[1] = 1'b0; tick(4);
    serve(); tick(3);
    ext_pin_n[1] = 1'b1; ret(); tick(3);

    // R10: level mode follows the pin, not latched, not cleared
    cur_req = "R10";
    wr_reg(2'd2, 8'h01);
    bus_addr = 2'd2;
    ext_pin_n[1] = 1'b0; tick(3);
    ext_pin_n[1] = 1'b1; tick(3);
    ext_pin_n[1] = 1'b0; tick(2);
    serve(); tick(2); ret(); tick(2);
    ext_pin_n[1] = 1'b1;
    serve(); tick(1); ret(); tick(3);

    // R13: offer held under back-pressure while a better request arrives
    cur_req = "R13";
    ser_flag = 1'b1; tick(3);
    tmr_flag[0] = 1'b1; tick(5);
    serve(); tick(1);
    ret(); ser_flag = 1'b0;
    serve(); tick(1); ret(); tick(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule